// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns an arbitrary system clock into single-cycle enable pulses for a serial link: one pulse stream at the bit rate and a second at eight times the bit rate, for use as an oversampling strobe by a receiver. Each stream comes from its own phase accumulator. On every enabled clock the accumulator adds a constant increment, and the carry out of its top bit is registered as the tick. The increment is a rounded fraction of 2^W, so the long-run rate has no cumulative error. The only error left is the rounding of that one constant.

Both increments are fixed when the design is elaborated. They come from the clock frequency, the bit rate and the accumulator width. The arithmetic is pre-scaled so that every intermediate value fits in 32 bits, and half a divisor is added so that the result is rounded rather than truncated. Elaboration stops with an error if an increment cannot give clean single-cycle pulses.

The reset input clears both accumulators asynchronously and is released synchronously. The enable input freezes both phases when it is low.

Top module: `baud_tick_gen`

## Requirements
- R1: Each tick is the registered carry out of a phase accumulator of ACC_W+1 bits that adds its increment on every enabled clock. Over any 2^ACC_W consecutive enabled cycles, the bit-rate tick is high exactly INC_1X times. INC_1X is 151 at the defaults (50 MHz, 115200 baud, ACC_W=16).
- R2: The increment is ((rate << (ACC_W-4)) + (CLK_HZ >> 5)) / (CLK_HZ >> 4). It is computed in 32-bit arithmetic and gives round(rate*2^ACC_W/CLK_HZ).
- R3: The oversampling tick has its own accumulator, whose increment uses the same formula at 8*BAUD. It is high exactly INC_8X times (1208 at the defaults) in any 2^ACC_W enabled cycles.
- R4: The average rate of each tick, measured over 2^ACC_W cycles, is within 0.5% of its requested rate (BAUD and 8*BAUD).
- R5: A tick is never high on two consecutive clock cycles.
- R6: While rst_n is low, both phases are zero and both ticks are low. Release of rst_n takes effect after two clock edges.
- R7: A clock edge with en low sets both ticks low from that edge and leaves both phases unchanged.
- R8: Elaboration fails if an increment is zero or is not less than 2^(ACC_W-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| en | input | 1 | Advances both accumulators when high |
| tick_1x | output | 1 | One-cycle pulse at the bit rate |
| tick_8x | output | 1 | One-cycle pulse at eight times the bit rate |

## Verification
A tick is registered, so it appears one clock edge after the add that overflows. It also drops one edge after the first edge at which en is sampled low. The bench therefore drives inputs and samples outputs on the falling edge. It starts every gated-off count only after the next rising edge. Once rst_n is released, the two-edge synchronizer delay is allowed for before any counting window opens. Each window spans exactly 2^ACC_W falling edges, so the exact tick counts of R1 and R3 hold whatever the starting phase.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

  // Rounded phase increment with every intermediate value kept inside 32 bits.
  function automatic int unsigned phase_inc(input int unsigned clk_hz,
                                            input int unsigned rate,
                                            input int unsigned acc_w);
    logic [31:0] numer;
    logic [31:0] denom;
    numer = (32'(rate) << (acc_w - 4)) + (32'(clk_hz) >> 5);
    denom = 32'(clk_hz) >> 4;
    return numer / denom;
  endfunction

endpackage

// File: rtl/baud_rst_sync.sv
module baud_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/baud_phase_acc.sv
module baud_phase_acc #(
  parameter int unsigned ACC_W = 16,
  parameter int unsigned INC   = 151
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);

  localparam logic [ACC_W:0] INC_EXT = (ACC_W+1)'(INC);
  localparam longint unsigned HALF_SPAN = 64'(1) << (ACC_W - 1);

  // R8: increment must give single-cycle, non-adjacent carries
  if (INC == 0 || 64'(INC) >= HALF_SPAN) begin : g_bad_inc
    $error("baud_phase_acc: increment %0d out of range for width %0d", INC, ACC_W);
  end

  logic [ACC_W-1:0] phase_q, phase_d;
  logic             carry_q, carry_d;
  logic [ACC_W:0]   sum;

  assign sum = {1'b0, phase_q} + INC_EXT;

  always_comb begin
    phase_d = phase_q;
    carry_d = 1'b0;
    if (en) begin
      phase_d = sum[ACC_W-1:0];
      carry_d = sum[ACC_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      carry_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      carry_q <= carry_d;
    end
  end

  assign tick = carry_q;

  assert_no_double_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  assert_gated_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!tick && phase_q == $past(phase_q)));

  assert_carry_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ({1'b0, phase_q} + INC_EXT) > {1'b0, {ACC_W{1'b1}}}) |=> tick);

  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R6: assert (phase_q == '0 && !tick);
    end
  end

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned BAUD   = 115_200,
  parameter int unsigned ACC_W  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick_1x,
  output logic tick_8x
);

  localparam int unsigned NUM_RATES = 2;

  logic                 rst_sync_n;
  logic [NUM_RATES-1:0] ticks;

  baud_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
    localparam int unsigned MULT = (g == 0) ? 1 : 8;
    localparam int unsigned INC  = baud_tick_pkg::phase_inc(CLK_HZ, BAUD * MULT, ACC_W);
    baud_phase_acc #(.ACC_W(ACC_W), .INC(INC)) u_acc (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .en    (en),
      .tick  (ticks[g])
    );
  end

  assign tick_1x = ticks[0];
  assign tick_8x = ticks[1];

endmodule

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;

  localparam int unsigned CLK_HZ = 50_000_000;
  localparam int unsigned BAUD   = 115_200;
  localparam int unsigned ACC_W  = 16;
  localparam longint SPAN = 64'(1) << ACC_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic tick_1x, tick_8x;

  int checks = 0;
  int fails = 0;
  int adjacent = 0;
  bit done = 1'b0;
  logic prev_1x = 1'b0, prev_8x = 1'b0;

  always #10 clk = ~clk;

  baud_tick_gen #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .ACC_W(ACC_W)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .tick_1x(tick_1x), .tick_8x(tick_8x)
  );

  function automatic longint exp_inc(input longint rate);
    return (rate * SPAN + CLK_HZ / 2) / CLK_HZ;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R5 monitor: no tick on two consecutive samples
  always @(negedge clk) begin
    if ((tick_1x && prev_1x) || (tick_8x && prev_8x)) adjacent++;
    prev_1x <= tick_1x;
    prev_8x <= tick_8x;
  end

  task automatic count_window(input longint n, output longint c1, output longint c8);
    c1 = 0; c8 = 0;
    for (longint i = 0; i < n; i++) begin
      @(negedge clk);
      c1 += longint'(tick_1x);
      c8 += longint'(tick_8x);
    end
  endtask

  task automatic test_reset();
    longint c1, c8;
    rst_n = 1'b0; en = 1'b1;
    count_window(20, c1, c8);
    check("R6 reset tick_1x", c1, 0);
    check("R6 reset tick_8x", c8, 0);
    @(negedge clk) rst_n = 1'b1;
    count_window(4, c1, c8);
  endtask

  task automatic test_exact_counts();
    longint c1, c8, target, err;
    count_window(SPAN, c1, c8);
    check("R1 R2 1x ticks per window", c1, exp_inc(BAUD));
    check("R3 8x ticks per window", c8, exp_inc(8 * BAUD));
    target = longint'(BAUD) * SPAN;
    err = c1 * CLK_HZ - target; if (err < 0) err = -err;
    check("R4 1x rate within 0.5%", longint'(err * 200 <= target), 1);
    target = longint'(BAUD) * 8 * SPAN;
    err = c8 * CLK_HZ - target; if (err < 0) err = -err;
    check("R4 8x rate within 0.5%", longint'(err * 200 <= target), 1);
    err = c8 - 8 * c1; if (err < 0) err = -err;
    check("R3 8x to 1x ratio", longint'(err <= 8), 1);
  endtask

  task automatic test_enable_gate();
    longint c1, c8;
    @(negedge clk) en = 1'b0;
    @(posedge clk);
    count_window(1500, c1, c8);
    check("R7 gated tick_1x", c1, 0);
    check("R7 gated tick_8x", c8, 0);
    en = 1'b1;
    count_window(SPAN, c1, c8);
    check("R1 1x count after gap", c1, exp_inc(BAUD));
    check("R3 8x count after gap", c8, exp_inc(8 * BAUD));
  endtask

  task automatic test_midrun_reset();
    longint c1, c8;
    @(negedge clk) rst_n = 1'b0;
    count_window(40, c1, c8);
    check("R6 midrun reset tick_1x", c1, 0);
    check("R6 midrun reset tick_8x", c8, 0);
    rst_n = 1'b1;
    count_window(4, c1, c8);
  endtask

  initial begin
    test_reset();
    test_exact_counts();
    test_enable_gate();
    test_midrun_reset();
    check("R5 no adjacent ticks", adjacent, 0);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(64'd20 * 64'd190_000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule